// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the write-side command interpreter for a parallel NOR flash array. Every bus write cycle carries a byte address, a data word and a strobe. The sequencer checks that cycle against a multi-step unlock handshake and walks a cycle-count state machine. A valid sequence ends in one of four ways: a single-word program, a sector erase, a whole-array erase, or a switch into the identification or parameter-query modes that a separate read path serves.

Programming reads the addressed word from a backing-memory port and writes it back ANDed with the bus data, so bits can only move from 1 to 0. An erase walks the affected words and writes all ones, one word per cycle. A countdown then holds the block busy for a fixed time, and a chip erase lasts ten times as long as a sector erase. A polling bit reports completion. An optional unlock-skip mode shortens later sequences to a single command write. A read-only input blocks every memory write while the state machine and the polling bit still advance as usual. The current command code and cycle state are exported so the read path can choose between array data, identification data, status and the query table.

Top module: `flash_cmd_seq`

## Requirements
- R1: The compared offset is the byte address masked to the sector size (2^SECT_AW bytes) and then shifted right by 1 for a 16-bit word or by 2 for a 32-bit word. An unlock write therefore matches in any sector, and at either byte of the word.
- R2: In idle (state 0), the data byte 0x98 at offset 0x55 enters query mode (state 7, command 0x98). 0xAA at offset UNLOCK0 moves to state 1. Any other write leaves the block in idle.
- R3: In state 1, 0x55 at offset UNLOCK1 moves to state 2. Any other write returns the block to idle.
- R4: In state 2, the address must match UNLOCK0 unless unlock-skip is on. The data byte 0x80, 0x90 or 0xA0 moves to state 3 with that command code. 0x20 turns unlock-skip on and stays in state 2. Any other byte resets the block.
- R5: In state 3 with command 0xA0, the next write stores (old word AND data) at the word address. The polling bit takes the inverse of data bit 7, and the block returns to idle.
- R6: In state 3 with command 0x80, 0xAA at UNLOCK0 (moving to state 4) and then 0x55 at UNLOCK1 (moving to state 5) are required. Next, 0x10 at UNLOCK0 fills every word with ones (command 0x10), and 0x30 at any address fills the words of the sector containing that address (command 0x30). Any other write resets the block.
- R7: An erase holds busy high and the state at 6 for exactly SECT_CYC cycles for a sector and SECT_CYC*10 cycles for the chip. The polling bit is 0 at the start and is inverted at the end. Every write that arrives while busy is high is ignored, including a write in the final busy cycle.
- R8: The data byte 0xF0 returns the block to idle, with command 0 and unlock-skip off, from any state outside an erase. The one exception is state 3 with command 0xA0, where 0xF0 is programmed as data.
- R9: With unlock-skip on, a finished program or erase returns the block to state 2. In state 3 with command 0x90, the byte 0x00 turns unlock-skip off and returns the block to idle.
- R10: In state 3 with command 0x90, 0x98 at offset 0x55 enters query mode (state 7).
- R11: Any write in query mode returns the block to idle with command 0.
- R12: While read_only is high, mem_we stays low. State, command code, busy and the polling bit behave as they would with read_only low.
- R13: The cycle-state codes are: 0 idle, 1 first unlock seen, 2 command expected, 3 argument expected, 4 and 5 second unlock steps, 6 erasing, 7 query. After reset the block is in state 0 with command 0, with busy, the polling bit and unlock-skip all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; commands use the low byte |
| read_only | input | 1 | Suppresses all memory modification |
| mem_rdata | input | DATA_W | Backing-memory read data for mem_addr (combinational) |
| mem_we | output | 1 | Backing-memory write enable |
| mem_addr | output | ADDR_W-SHIFT | Backing-memory word address |
| mem_wdata | output | DATA_W | Backing-memory write data |
| busy | output | 1 | Erase in progress |
| poll_bit | output | 1 | Completion polling bit |
| bypass_on | output | 1 | Unlock-skip mode active |
| cmd_code | output | 8 | Current command code |
| cyc_state | output | 3 | Current cycle-state code |

## Verification
The end of an erase countdown and an incoming bus write can land in the same cycle. The block must drop the write and still invert the polling bit and leave state 6. The bench provokes this by holding a valid first-unlock write on the bus from three cycles before expiry until one cycle after it. The reference model then expects the write in the expiry cycle to be dropped and the following write to be accepted, and a dedicated check looks at the state right after expiry.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_UNL1  = 3'd1,
      ST_CMD   = 3'd2,
      ST_ARG   = 3'd3,
      ST_EUNL1 = 3'd4,
      ST_ESEL  = 3'd5,
      ST_BUSY  = 3'd6,
      ST_CFI   = 3'd7
   } seq_state_e;

   localparam logic [7:0] K_UNL_A      = 8'hAA;
   localparam logic [7:0] K_UNL_B      = 8'h55;
   localparam logic [7:0] K_ERASE_SET  = 8'h80;
   localparam logic [7:0] K_AUTOSEL    = 8'h90;
   localparam logic [7:0] K_PROGRAM    = 8'hA0;
   localparam logic [7:0] K_SKIP_ON    = 8'h20;
   localparam logic [7:0] K_CHIP_ERASE = 8'h10;
   localparam logic [7:0] K_SECT_ERASE = 8'h30;
   localparam logic [7:0] K_QUERY      = 8'h98;
   localparam logic [7:0] K_RESET      = 8'hF0;
   localparam logic [7:0] K_SKIP_OFF   = 8'h00;
   localparam logic [15:0] QUERY_OFF   = 16'h0055;

endpackage

// File: rtl/flash_addr_dec.sv
module flash_addr_dec #(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 16,
   parameter int SECT_AW = 8,
   localparam int SHIFT   = (DATA_W == 32) ? 2 : ((DATA_W == 16) ? 1 : 0),
   localparam int WORD_AW = ADDR_W - SHIFT,
   localparam int OFF_W   = SECT_AW - SHIFT
) (
   input  logic [ADDR_W-1:0]  byte_addr,
   output logic [WORD_AW-1:0] word_addr,
   output logic [WORD_AW-1:0] sect_base,
   output logic [15:0]        sect_off
);

   generate
      case (DATA_W)
         8: begin : g_w8
            assign word_addr = byte_addr;
            assign sect_off  = 16'(byte_addr[SECT_AW-1:0]);
         end
         16: begin : g_w16
            assign word_addr = byte_addr[ADDR_W-1:1];
            assign sect_off  = 16'(byte_addr[SECT_AW-1:1]);
         end
         32: begin : g_w32
            assign word_addr = byte_addr[ADDR_W-1:2];
            assign sect_off  = 16'(byte_addr[SECT_AW-1:2]);
         end
         default: begin : g_bad
            $error("flash_addr_dec: DATA_W must be 8, 16 or 32");
         end
      endcase
   endgenerate

   assign sect_base = {byte_addr[ADDR_W-1:SECT_AW], {OFF_W{1'b0}}};

endmodule

// File: rtl/flash_erase_eng.sv
module flash_erase_eng #(
   parameter int WORD_AW  = 10,
   parameter int OFF_W    = 7,
   parameter int SECT_CYC = 150,
   parameter int CHIP_MUL = 10,
   localparam int CHIP_CYC   = SECT_CYC * CHIP_MUL,
   localparam int TMR_W      = $clog2(CHIP_CYC + 1),
   localparam int CHIP_WORDS = 1 << WORD_AW,
   localparam int SECT_WORDS = 1 << OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               chip,
   input  logic [WORD_AW-1:0] base_word,
   output logic               active,
   output logic               last,
   output logic               fill_we,
   output logic [WORD_AW-1:0] fill_addr
);

   if (SECT_CYC < SECT_WORDS) begin : g_chk_sect
      $error("flash_erase_eng: SECT_CYC shorter than sector fill");
   end
   if (CHIP_CYC < CHIP_WORDS) begin : g_chk_chip
      $error("flash_erase_eng: chip erase time shorter than array fill");
   end

   logic [TMR_W-1:0]   tmr_q;
   logic [WORD_AW:0]   left_q;
   logic [WORD_AW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         tmr_q  <= '0;
         left_q <= '0;
         ptr_q  <= '0;
      end else if (start) begin
         active <= 1'b1;
         tmr_q  <= chip ? TMR_W'(CHIP_CYC) : TMR_W'(SECT_CYC);
         left_q <= chip ? (WORD_AW+1)'(CHIP_WORDS) : (WORD_AW+1)'(SECT_WORDS);
         ptr_q  <= chip ? '0 : base_word;
      end else if (active) begin
         if (tmr_q == TMR_W'(1)) active <= 1'b0;
         else                   tmr_q  <= tmr_q - TMR_W'(1);
         if (left_q != '0) begin
            left_q <= left_q - (WORD_AW+1)'(1);
            ptr_q  <= ptr_q + WORD_AW'(1);
         end
      end
   end

   assign last      = active && (tmr_q == TMR_W'(1));
   assign fill_we   = active && (left_q != '0);
   assign fill_addr = ptr_q;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_seq_pkg::*;
#(
   parameter int          ADDR_W   = 11,
   parameter int          DATA_W   = 16,
   parameter int          SECT_AW  = 8,
   parameter int          SECT_CYC = 150,
   parameter int          CHIP_MUL = 10,
   parameter logic [15:0] UNLOCK0  = 16'h0055,
   parameter logic [15:0] UNLOCK1  = 16'h002A,
   localparam int SHIFT   = (DATA_W == 32) ? 2 : ((DATA_W == 16) ? 1 : 0),
   localparam int WORD_AW = ADDR_W - SHIFT,
   localparam int OFF_W   = SECT_AW - SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               read_only,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               mem_we,
   output logic [WORD_AW-1:0] mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               busy,
   output logic               poll_bit,
   output logic               bypass_on,
   output logic [7:0]         cmd_code,
   output logic [2:0]         cyc_state
);

   if (OFF_W < 7) begin : g_chk_off
      $error("flash_cmd_seq: sector too small to hold the query offset");
   end
   if (UNLOCK0 >= 16'(1 << OFF_W) || UNLOCK1 >= 16'(1 << OFF_W)) begin : g_chk_unl
      $error("flash_cmd_seq: unlock offsets exceed sector word range");
   end
   if (SECT_AW >= ADDR_W) begin : g_chk_sz
      $error("flash_cmd_seq: need more than one sector");
   end

   logic [WORD_AW-1:0] word_addr, sect_base, fill_addr;
   logic [15:0]        off;
   logic               eng_last, fill_we;

   flash_addr_dec #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SECT_AW(SECT_AW)
   ) u_dec (
      .byte_addr(wr_addr),
      .word_addr(word_addr),
      .sect_base(sect_base),
      .sect_off (off)
   );

   seq_state_e st_q, st_d;
   logic [7:0] cmd_q, cmd_d;
   logic       byp_q, byp_d;
   logic       poll_q, poll_d;
   logic       er_start, er_chip, prog_req;

   logic [7:0] db;
   logic       at_u0, at_u1, at_qry;

   assign db     = wr_data[7:0];
   assign at_u0  = (off == UNLOCK0);
   assign at_u1  = (off == UNLOCK1);
   assign at_qry = (off == QUERY_OFF);

   flash_erase_eng #(
      .WORD_AW (WORD_AW),
      .OFF_W   (OFF_W),
      .SECT_CYC(SECT_CYC),
      .CHIP_MUL(CHIP_MUL)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (er_start),
      .chip     (er_chip),
      .base_word(sect_base),
      .active   (busy),
      .last     (eng_last),
      .fill_we  (fill_we),
      .fill_addr(fill_addr)
   );

   always_comb begin
      st_d     = st_q;
      cmd_d    = cmd_q;
      byp_d    = byp_q;
      poll_d   = poll_q;
      er_start = 1'b0;
      er_chip  = 1'b0;
      prog_req = 1'b0;

      if (st_q == ST_BUSY) begin
         if (eng_last) begin
            st_d   = byp_q ? ST_CMD : ST_IDLE;
            cmd_d  = 8'h00;
            poll_d = ~poll_q;
         end
      end else if (wr_en) begin
         if (db == K_RESET && !(st_q == ST_ARG && cmd_q == K_PROGRAM)) begin
            st_d  = ST_IDLE;
            cmd_d = 8'h00;
            byp_d = 1'b0;
         end else begin
            // default outcome of a rejected write
            st_d  = ST_IDLE;
            cmd_d = 8'h00;
            byp_d = 1'b0;
            unique case (st_q)
               ST_IDLE: begin
                  if (at_qry && db == K_QUERY) begin
                     st_d  = ST_CFI;
                     cmd_d = K_QUERY;
                  end else if (at_u0 && db == K_UNL_A) begin
                     st_d = ST_UNL1;
                  end
               end
               ST_UNL1: begin
                  if (at_u1 && db == K_UNL_B) st_d = ST_CMD;
               end
               ST_CMD: begin
                  if (byp_q || at_u0) begin
                     if (db == K_SKIP_ON) begin
                        st_d  = ST_CMD;
                        byp_d = 1'b1;
                     end else if (db == K_ERASE_SET || db == K_AUTOSEL || db == K_PROGRAM) begin
                        st_d  = ST_ARG;
                        cmd_d = db;
                        byp_d = byp_q;
                     end
                  end
               end
               ST_ARG: begin
                  if (cmd_q == K_PROGRAM) begin
                     prog_req = 1'b1;
                     poll_d   = ~wr_data[7];
                     st_d     = byp_q ? ST_CMD : ST_IDLE;
                     byp_d    = byp_q;
                  end else if (cmd_q == K_AUTOSEL) begin
                     if (!(byp_q && db == K_SKIP_OFF) && at_qry && db == K_QUERY) begin
                        st_d  = ST_CFI;
                        cmd_d = K_QUERY;
                        byp_d = byp_q;
                     end
                  end else if (cmd_q == K_ERASE_SET) begin
                     if (at_u0 && db == K_UNL_A) begin
                        st_d  = ST_EUNL1;
                        cmd_d = cmd_q;
                        byp_d = byp_q;
                     end
                  end
               end
               ST_EUNL1: begin
                  if (at_u1 && db == K_UNL_B) begin
                     st_d  = ST_ESEL;
                     cmd_d = cmd_q;
                     byp_d = byp_q;
                  end
               end
               ST_ESEL: begin
                  if ((db == K_CHIP_ERASE && at_u0) || db == K_SECT_ERASE) begin
                     st_d     = ST_BUSY;
                     cmd_d    = db;
                     byp_d    = byp_q;
                     poll_d   = 1'b0;
                     er_start = 1'b1;
                     er_chip  = (db == K_CHIP_ERASE);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cmd_q  <= 8'h00;
         byp_q  <= 1'b0;
         poll_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cmd_q  <= cmd_d;
         byp_q  <= byp_d;
         poll_q <= poll_d;
      end
   end

   assign mem_we    = !read_only && (prog_req || fill_we);
   assign mem_addr  = fill_we ? fill_addr : word_addr;
   assign mem_wdata = fill_we ? {DATA_W{1'b1}} : (mem_rdata & wr_data);

   assign poll_bit  = poll_q;
   assign bypass_on = byp_q;
   assign cmd_code  = cmd_q;
   assign cyc_state = st_q;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 16,
   parameter int WORD_AW = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic               read_only,
   input logic [DATA_W-1:0]  mem_rdata,
   input logic               mem_we,
   input logic [WORD_AW-1:0] mem_addr,
   input logic [DATA_W-1:0]  mem_wdata,
   input logic               busy,
   input logic               poll_bit,
   input logic               bypass_on,
   input logic [7:0]         cmd_code,
   input logic [2:0]         cyc_state
);

   // R5: a program write never raises a bit of the stored word
   a_r5_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !busy) |-> ((mem_wdata & ~mem_rdata) == '0));

   // R6: erase writes are all ones
   a_r6_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && busy) |-> (mem_wdata == {DATA_W{1'b1}}));

   // R7: erasing state matches the busy flag
   a_r7_busy_state: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cyc_state == 3'd6));

   // R7: polling bit low at erase start
   a_r7_poll_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !poll_bit);

   // R7: polling bit inverted at erase end
   a_r7_poll_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> poll_bit);

   // R8: reset byte returns to idle outside program-data and erase
   a_r8_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[7:0] == 8'hF0 && !busy && !(cyc_state == 3'd3 && cmd_code == 8'hA0))
      |=> (cyc_state == 3'd0 && !bypass_on && cmd_code == 8'h00));

   // R11: any write in query mode leaves it
   a_r11_query_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_state == 3'd7 && wr_en) |=> (cyc_state == 3'd0));

   // R12: read-only blocks memory writes
   a_r12_ro_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      read_only |-> !mem_we);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .WORD_AW(WORD_AW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .read_only(read_only),
   .mem_rdata(mem_rdata),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .busy     (busy),
   .poll_bit (poll_bit),
   .bypass_on(bypass_on),
   .cmd_code (cmd_code),
   .cyc_state(cyc_state)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW     = 11;
   localparam int DW     = 16;
   localparam int WORDS  = 1024;
   localparam int SWORDS = 128;
   localparam int T_SECT = 150;
   localparam int T_CHIP = 1500;
   localparam int U0B    = 'hAA;   // byte address of offset 0x55
   localparam int U1B    = 'h54;   // byte address of offset 0x2A

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic read_only = 1'b0;
   logic [DW-1:0] mem_rdata;
   logic mem_we, busy, poll_bit, bypass_on;
   logic [9:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [7:0] cmd_code;
   logic [2:0] cyc_state;

   logic [DW-1:0] dmem [0:WORDS-1];
   logic [DW-1:0] m_mem [0:WORDS-1];

   int n_chk = 0, n_err = 0;
   bit cmp_on = 0, done = 0;
   string cur_req = "R13";

   int m_state, m_cmd, m_byp, m_poll, m_busy, m_tmr;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_seq dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .read_only(read_only), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .busy(busy), .poll_bit(poll_bit), .bypass_on(bypass_on),
      .cmd_code(cmd_code), .cyc_state(cyc_state)
   );

   assign mem_rdata = dmem[mem_addr];
   always @(posedge clk) if (mem_we) dmem[mem_addr] <= mem_wdata;

   // behavioural reference model
   task automatic m_reset_seq();
      m_state = 0; m_cmd = 0; m_byp = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_cmd = 0; m_byp = 0; m_poll = 0; m_busy = 0; m_tmr = 0;
      end else if (m_busy) begin
         if (m_tmr == 1) begin
            m_busy = 0; m_state = m_byp ? 2 : 0; m_cmd = 0; m_poll = !m_poll;
         end else m_tmr--;
      end else if (wr_en) begin
         int off, w, d;
         off = (int'(wr_addr) % 256) / 2;
         w   = int'(wr_addr) / 2;
         d   = int'(wr_data[7:0]);
         if (d == 'hF0 && !(m_state == 3 && m_cmd == 'hA0)) m_reset_seq();
         else begin
            case (m_state)
               0: if (off == 'h55 && d == 'h98) begin m_state = 7; m_cmd = 'h98; end
                  else if (off == 'h55 && d == 'hAA) m_state = 1;
                  else m_reset_seq();
               1: if (off == 'h2A && d == 'h55) m_state = 2; else m_reset_seq();
               2: if (!m_byp && off != 'h55) m_reset_seq();
                  else if (d == 'h20) m_byp = 1;
                  else if (d == 'h80 || d == 'h90 || d == 'hA0) begin m_state = 3; m_cmd = d; end
                  else m_reset_seq();
               3: if (m_cmd == 'hA0) begin
                     if (!read_only) m_mem[w] = m_mem[w] & wr_data;
                     m_poll = !wr_data[7];
                     m_state = m_byp ? 2 : 0; m_cmd = 0;
                  end else if (m_cmd == 'h90) begin
                     if (m_byp && d == 0) m_reset_seq();
                     else if (off == 'h55 && d == 'h98) begin m_state = 7; m_cmd = 'h98; end
                     else m_reset_seq();
                  end else begin
                     if (off == 'h55 && d == 'hAA) m_state = 4; else m_reset_seq();
                  end
               4: if (off == 'h2A && d == 'h55) m_state = 5; else m_reset_seq();
               5: if ((d == 'h10 && off == 'h55) || d == 'h30) begin
                     int lo, n;
                     lo = (d == 'h10) ? 0 : (w / SWORDS) * SWORDS;
                     n  = (d == 'h10) ? WORDS : SWORDS;
                     if (!read_only) for (int i = lo; i < lo + n; i++) m_mem[i] = '1;
                     m_state = 6; m_cmd = d; m_poll = 0; m_busy = 1;
                     m_tmr = (d == 'h10) ? T_CHIP : T_SECT;
                  end else m_reset_seq();
               default: m_reset_seq();
            endcase
         end
      end
   end

   // per-clock comparison
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         n_chk++;
         if (int'(cyc_state) != m_state || int'(cmd_code) != m_cmd || int'(busy) != m_busy ||
             int'(poll_bit) != m_poll || int'(bypass_on) != m_byp) begin
            n_err++;
            $display("FAIL %s: state/cmd/busy/poll/byp act=%0d/%02h/%0d/%0d/%0d exp=%0d/%02h/%0d/%0d/%0d",
                     cur_req, cyc_state, cmd_code, busy, poll_bit, bypass_on,
                     m_state, m_cmd, m_busy, m_poll, m_byp);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic mem_chk(input string req);
      int bad;
      bad = -1;
      for (int i = 0; i < WORDS; i++) if (bad < 0 && dmem[i] !== m_mem[i]) bad = i;
      n_chk++;
      if (bad >= 0) begin
         n_err++;
         $display("FAIL %s: word %0d act=%04h exp=%04h", req, bad, dmem[bad], m_mem[bad]);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      wr(U0B, 'hAA); wr(U1B, 'h55);
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: act=timeout exp=finish");
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int n;
      for (int i = 0; i < WORDS; i++) begin
         dmem[i]  = DW'((i * 'h1357) ^ 'hA5A5);
         m_mem[i] = DW'((i * 'h1357) ^ 'hA5A5);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1;
      // R13 reset state
      chk(cyc_state == 0 && cmd_code == 0 && !busy && !poll_bit && !bypass_on && !mem_we,
          "R13", {cyc_state, cmd_code}, 0);

      // R4 / R5 program
      cur_req = "R4";
      unlock(); wr(U0B, 'hA0);
      chk(cyc_state == 3 && cmd_code == 'hA0, "R4", {cyc_state, cmd_code}, 'h3A0);
      cur_req = "R5";
      wr(600, 'h0F0F);
      chk(poll_bit == 1 && cyc_state == 0, "R5", poll_bit, 1);
      unlock(); wr(U0B, 'hA0); wr(600, 'hFFFF);
      mem_chk("R5");

      // R1 unlock in another sector at the odd byte, R10 query from autoselect, R11 exit
      cur_req = "R1";
      wr('h3AB, 'hAA); wr('h354, 'h55);
      chk(cyc_state == 2, "R1", cyc_state, 2);
      wr('h2AA, 'h90);
      cur_req = "R10";
      wr(U0B, 'h98);
      chk(cyc_state == 7 && cmd_code == 'h98, "R10", cyc_state, 7);
      cur_req = "R11";
      wr(0, 'h1234);
      chk(cyc_state == 0 && cmd_code == 0, "R11", cyc_state, 0);

      // R2 direct query entry and wrong first address
      cur_req = "R2";
      wr(U0B, 'h98);
      chk(cyc_state == 7, "R2", cyc_state, 7);
      wr(U0B, 'h00);
      wr(U1B, 'hAA);
      chk(cyc_state == 0, "R2", cyc_state, 0);

      // R3 bad second cycle
      cur_req = "R3";
      wr(U0B, 'hAA); wr(U0B, 'h55);
      chk(cyc_state == 0, "R3", cyc_state, 0);

      // R4 unknown command
      cur_req = "R4";
      unlock(); wr(U0B, 'h77);
      chk(cyc_state == 0, "R4", cyc_state, 0);

      // R8 reset byte and program of F0 data
      cur_req = "R8";
      unlock(); wr(U0B, 'hF0);
      chk(cyc_state == 0, "R8", cyc_state, 0);
      unlock(); wr(U0B, 'hA0); wr(700, 'h12F0);
      mem_chk("R8");

      // R12 read-only program and chip erase
      cur_req = "R12";
      read_only = 1'b1;
      unlock(); wr(U0B, 'hA0); wr(800, 'h0000);
      chk(poll_bit == 1, "R12", poll_bit, 1);
      unlock(); wr(U0B, 'h80); unlock(); wr(U0B, 'h10);
      chk(busy == 1, "R12", busy, 1);
      count_busy(n);
      mem_chk("R12");
      read_only = 1'b0;

      // R6 / R7 sector erase timing
      cur_req = "R7";
      unlock(); wr(U0B, 'h80); unlock(); wr(800, 'h30);
      count_busy(n);
      chk(n == T_SECT, "R7", n, T_SECT);
      mem_chk("R6");

      // R7 write colliding with expiry
      unlock(); wr(U0B, 'h80); unlock(); wr(100, 'h30);
      while (!(m_busy && m_tmr == 3)) @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(U0B); wr_data = 'h00AA;
      repeat (3) @(negedge clk);
      chk(cyc_state == 0 && !busy, "R7", cyc_state, 0);
      @(negedge clk);
      chk(cyc_state == 1, "R7", cyc_state, 1);
      wr_en = 1'b0;
      wr(U0B, 'hF0);

      // R6 chip erase, ten times longer
      cur_req = "R6";
      unlock(); wr(U0B, 'h80); unlock(); wr(U0B, 'h10);
      count_busy(n);
      chk(n == T_CHIP, "R7", n, T_CHIP);
      mem_chk("R6");

      // R9 unlock-skip mode
      cur_req = "R9";
      unlock(); wr(U0B, 'h20);
      chk(bypass_on == 1 && cyc_state == 2, "R9", bypass_on, 1);
      wr('h10, 'hA0);
      chk(cyc_state == 3, "R9", cyc_state, 3);
      wr(900, 'h00FF);
      chk(cyc_state == 2 && bypass_on == 1, "R9", cyc_state, 2);
      wr(4, 'h90); wr(4, 'h00);
      chk(cyc_state == 0 && bypass_on == 0, "R9", bypass_on, 0);
      unlock(); wr(U0B, 'h20); wr(6, 'h80); unlock(); wr('h100, 'h30);
      count_busy(n);
      chk(cyc_state == 2 && bypass_on == 1, "R9", cyc_state, 2);
      cur_req = "R8";
      wr(8, 'hF0);
      chk(cyc_state == 0 && bypass_on == 0, "R8", bypass_on, 0);
      mem_chk("R9");

      repeat (2) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule